// File: doc/BRIEF.md
# Packed SIMD Saturating Adder

This unit adds or subtracts two 64-bit operands that are treated as a packed vector of equal-width lanes. A two-bit lane selector cuts the operands into eight 8-bit, four 16-bit, two 32-bit or one 64-bit lane, and every lane carries out the same operation in the same cycle. A carry or borrow never leaves its lane.

Three kinds of arithmetic are available. Wrapping arithmetic drops the carry out of each lane. Unsigned saturation clamps each lane at its all-ones maximum or at zero. Signed saturation clamps each lane at the most positive or most negative two's-complement value of its width. The result is held in one register stage. The output valid repeats the input valid one clock later, and the result holds its value on cycles without a valid input.

Top module: `simd_sat_add`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `result` is all zeros.
- R2: With `sat_mode` = 00 (wrap), each lane returns (a ± b) modulo 2^w. `lane_mode` selects w: 00 gives 8 bits, 01 gives 16, 10 gives 32 and 11 gives 64. Lane k occupies bits [k·w+w−1 : k·w]. A carry or borrow never crosses from one lane into the next.
- R3: With `sat_mode` = 01 and `op_sub` = 0, a lane whose unsigned sum exceeds 2^w−1 outputs all ones. Every other lane outputs its exact sum.
- R4: With `sat_mode` = 01 and `op_sub` = 1, a lane where b > a outputs zero. Every other lane outputs a−b.
- R5: With `sat_mode` = 10, each lane is treated as a two's-complement value. A lane whose result overflows outputs 2^(w−1)−1 for a positive overflow and −2^(w−1) for a negative overflow.
- R6: `out_valid` equals `in_valid` from the previous clock. The `result` computed from the inputs sampled at that edge appears in that same cycle.
- R7: On a clock where `in_valid` is 0, `result` keeps its previous value.
- R8: `sat_mode` = 11 behaves exactly like wrap mode.
- R9: Repeatedly adding 1 in unsigned saturating byte mode makes every byte count up normally. Once a byte reaches 0xFF it stays there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| lane_mode | input | 2 | Lane width: 00 = 8, 01 = 16, 10 = 32, 11 = 64 bits |
| op_sub | input | 1 | 0 = add, 1 = subtract (a − b) |
| sat_mode | input | 2 | 00 = wrap, 01 = unsigned saturate, 10 = signed saturate, 11 = wrap |
| src_a | input | 64 | First operand (minuend) |
| src_b | input | 64 | Second operand (subtrahend) |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 64 | Registered packed result |

## Verification
The only internal state is the output register and its valid flag. Any corruption therefore shows at the ports on the very next clock, as a wrong lane value or a valid that does not track the input. A carry chain that leaks across a lane boundary shows up only when the lower lane produces a carry. The bench drives all-ones and near-boundary patterns in every lane width for that reason. A wrong clamp condition in one lane leaves its neighbours correct, so every result is compared lane by lane against a behavioural model on every cycle.

// File: rtl/simd_pkg.sv
package simd_pkg;

    typedef enum logic [1:0] {
        LANE_B8  = 2'b00,
        LANE_W16 = 2'b01,
        LANE_D32 = 2'b10,
        LANE_Q64 = 2'b11
    } lane_e;

    typedef enum logic [1:0] {
        ARITH_WRAP = 2'b00,
        ARITH_USAT = 2'b01,
        ARITH_SSAT = 2'b10,
        ARITH_RSVD = 2'b11
    } arith_e;

endpackage

// File: rtl/simd_slice_chain.sv
module simd_slice_chain #(
    parameter int SLICE_W = 8,
    parameter int NSLICE  = 8,
    parameter int MODE_W  = 2,
    localparam int DATA_W = SLICE_W * NSLICE
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              do_sub,
    input  logic [MODE_W-1:0] width_sel,
    output logic [DATA_W-1:0] raw_sum,
    output logic [NSLICE-1:0] slice_cout,
    output logic [NSLICE-1:0] slice_sovf
);

    logic [NSLICE-1:0] slice_start;

    // A slice starts a new lane when its index is a multiple of the lane span.
    always_comb begin
        for (int i = 0; i < NSLICE; i++) begin
            slice_start[i] = ((i % (1 << width_sel)) == 0);
        end
    end

    always_comb begin
        logic              carry;
        logic [SLICE_W-1:0] av, bv;
        logic [SLICE_W:0]   s9;
        carry = do_sub;
        for (int i = 0; i < NSLICE; i++) begin
            if (slice_start[i]) carry = do_sub;
            av = a_in[i*SLICE_W +: SLICE_W];
            bv = do_sub ? ~b_in[i*SLICE_W +: SLICE_W] : b_in[i*SLICE_W +: SLICE_W];
            s9 = {1'b0, av} + {1'b0, bv} + {{SLICE_W{1'b0}}, carry};
            raw_sum[i*SLICE_W +: SLICE_W] = s9[SLICE_W-1:0];
            slice_cout[i] = s9[SLICE_W];
            slice_sovf[i] = (av[SLICE_W-1] == bv[SLICE_W-1]) &&
                            (s9[SLICE_W-1] != av[SLICE_W-1]);
            carry = s9[SLICE_W];
        end
    end

endmodule

// File: rtl/simd_clamp.sv
module simd_clamp
    import simd_pkg::*;
#(
    parameter int SLICE_W = 8,
    parameter int NSLICE  = 8,
    parameter int MODE_W  = 2,
    localparam int DATA_W = SLICE_W * NSLICE,
    localparam int IDX_W  = (NSLICE > 1) ? $clog2(NSLICE) : 1
) (
    input  logic [DATA_W-1:0] raw_sum,
    input  logic [NSLICE-1:0] slice_cout,
    input  logic [NSLICE-1:0] slice_sovf,
    input  logic              do_sub,
    input  arith_e            arith,
    input  logic [MODE_W-1:0] width_sel,
    output logic [DATA_W-1:0] clamped
);

    logic [IDX_W-1:0] span;
    assign span = IDX_W'((1 << width_sel) - 1);

    for (genvar i = 0; i < NSLICE; i++) begin : g_byte
        logic [IDX_W-1:0]   top;
        logic               is_top;
        logic               u_ovf;
        logic               s_ovf;
        logic               neg_clip;
        logic [SLICE_W-1:0] own;

        assign top      = IDX_W'(i) | span;
        assign is_top   = (IDX_W'(i) == top);
        assign u_ovf    = do_sub ? ~slice_cout[top] : slice_cout[top];
        assign s_ovf    = slice_sovf[top];
        // overflowed result sign is inverted: msb 0 means it wrapped negative-to-positive
        assign neg_clip = ~raw_sum[top*SLICE_W + SLICE_W - 1];
        assign own      = raw_sum[i*SLICE_W +: SLICE_W];

        always_comb begin
            unique case (arith)
                ARITH_USAT: begin
                    if (u_ovf) clamped[i*SLICE_W +: SLICE_W] = do_sub ? '0 : '1;
                    else       clamped[i*SLICE_W +: SLICE_W] = own;
                end
                ARITH_SSAT: begin
                    if (!s_ovf)       clamped[i*SLICE_W +: SLICE_W] = own;
                    else if (neg_clip) clamped[i*SLICE_W +: SLICE_W] =
                        is_top ? {1'b1, {(SLICE_W-1){1'b0}}} : '0;
                    else               clamped[i*SLICE_W +: SLICE_W] =
                        is_top ? {1'b0, {(SLICE_W-1){1'b1}}} : '1;
                end
                ARITH_WRAP, ARITH_RSVD: clamped[i*SLICE_W +: SLICE_W] = own;
                default:                clamped[i*SLICE_W +: SLICE_W] = own;
            endcase
        end
    end

endmodule

// File: rtl/simd_sat_add.sv
module simd_sat_add
    import simd_pkg::*;
#(
    parameter int SLICE_W = 8,
    parameter int NSLICE  = 8,
    parameter int MODE_W  = 2,
    localparam int DATA_W = SLICE_W * NSLICE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [MODE_W-1:0] lane_mode,
    input  logic              op_sub,
    input  logic [1:0]        sat_mode,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);

    arith_e            arith;
    logic [DATA_W-1:0] raw_sum;
    logic [DATA_W-1:0] clamped;
    logic [NSLICE-1:0] slice_cout;
    logic [NSLICE-1:0] slice_sovf;

    assign arith = arith_e'(sat_mode);

    simd_slice_chain #(.SLICE_W(SLICE_W), .NSLICE(NSLICE), .MODE_W(MODE_W)) i_chain (
        .a_in       (src_a),
        .b_in       (src_b),
        .do_sub     (op_sub),
        .width_sel  (lane_mode),
        .raw_sum    (raw_sum),
        .slice_cout (slice_cout),
        .slice_sovf (slice_sovf)
    );

    simd_clamp #(.SLICE_W(SLICE_W), .NSLICE(NSLICE), .MODE_W(MODE_W)) i_clamp (
        .raw_sum    (raw_sum),
        .slice_cout (slice_cout),
        .slice_sovf (slice_sovf),
        .do_sub     (op_sub),
        .arith      (arith),
        .width_sel  (lane_mode),
        .clamped    (clamped)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= clamped;
        end
    end

    // R6: valid tracks the previous cycle's input valid
    assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R7: result is held across idle cycles
    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    // R2: full-width wrap add equals plain modular sum
    assert_wrap_quad_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_mode == MODE_W'(3) && arith == ARITH_WRAP && !op_sub)
        |=> result == $past(src_a + src_b));

    // R3: unsigned saturating add never falls below the first operand
    assert_usat_add_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_mode == MODE_W'(3) && arith == ARITH_USAT && !op_sub)
        |=> result >= $past(src_a));

    // R4: unsigned saturating subtract never exceeds the first operand
    assert_usat_sub_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_mode == MODE_W'(3) && arith == ARITH_USAT && op_sub)
        |=> result <= $past(src_a));

endmodule

// File: tb/test_simd_sat_add.sv
module test_simd_sat_add;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  lane_mode = 2'b00;
    logic        op_sub = 1'b0;
    logic [1:0]  sat_mode = 2'b00;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        out_valid;
    logic [63:0] result;

    int          n_checks = 0;
    int          n_fail = 0;
    logic [63:0] last_exp = '0;
    bit          done = 1'b0;

    always #10ns clk = ~clk;

    simd_sat_add i_simd_sat_add (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lane_mode(lane_mode),
        .op_sub(op_sub), .sat_mode(sat_mode), .src_a(src_a), .src_b(src_b),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b,
                                          logic [1:0] mode, logic sub, logic [1:0] ar);
        int          w;
        int          n;
        logic [63:0] r;
        w = 8 << mode;
        n = 64 / w;
        r = '0;
        for (int l = 0; l < n; l++) begin
            logic signed [67:0] mask, ua, ub, x, mx, mn;
            mask = (68'sd1 <<< w) - 68'sd1;
            ua = (68'(a) >> (l * w)) & mask;
            ub = (68'(b) >> (l * w)) & mask;
            if (ar == 2'b01) begin
                x = sub ? ua - ub : ua + ub;
                if (x > mask) x = mask;
                if (x < 0)    x = 0;
            end else if (ar == 2'b10) begin
                if (ua[w-1]) ua = ua - (mask + 68'sd1);
                if (ub[w-1]) ub = ub - (mask + 68'sd1);
                mx = (68'sd1 <<< (w - 1)) - 68'sd1;
                mn = -(mx + 68'sd1);
                x = sub ? ua - ub : ua + ub;
                if (x > mx) x = mx;
                if (x < mn) x = mn;
                x = x & mask;
            end else begin
                x = (sub ? ua - ub : ua + ub) & mask;
            end
            r = r | (64'(x) << (l * w));
        end
        return r;
    endfunction

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Drives one vector at a falling edge, checks it one cycle later.
    task automatic apply(string tag, logic [63:0] a, logic [63:0] b,
                         logic [1:0] mode, logic sub, logic [1:0] ar);
        logic [63:0] exp;
        exp = model(a, b, mode, sub, ar);
        in_valid = 1'b1; src_a = a; src_b = b;
        lane_mode = mode; op_sub = sub; sat_mode = ar;
        @(negedge clk);
        check({tag, " valid"}, {63'd0, out_valid}, 64'd1);
        check(tag, result, exp);
        last_exp = exp;
    endtask

    task automatic idle(string tag);
        in_valid = 1'b0;
        src_a = 64'hDEAD_BEEF_0123_4567; src_b = 64'hFFFF_0000_FFFF_0000;
        @(negedge clk);
        check({tag, " valid"}, {63'd0, out_valid}, 64'd0);
        check(tag, result, last_exp);
    endtask

    initial begin
        #(20ns * 150000);
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] acc;
        repeat (3) @(negedge clk);
        check("R1 reset valid", {63'd0, out_valid}, 64'd0);
        check("R1 reset result", result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 wrap in each lane width, carries must stay in lane
        apply("R2 byte wrap", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'b00, 1'b0, 2'b00);
        apply("R2 word wrap", 64'h00FF_FFFF_7FFF_8000, 64'h0001_0001_0001_8000, 2'b01, 1'b0, 2'b00);
        apply("R2 dword wrap", 64'hFFFF_FFFF_0000_0000, 64'h0000_0001_0000_0001, 2'b10, 1'b1, 2'b00);
        apply("R2 quad wrap", 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 2'b11, 1'b0, 2'b00);
        apply("R2 byte borrow", 64'h0000_0000_0000_0000, 64'h0001_0000_0100_0001, 2'b00, 1'b1, 2'b00);
        // R3 unsigned saturating add
        apply("R3 byte usat add", 64'hF0F0_1010_FF00_7F80, 64'h2010_1010_0101_8080, 2'b00, 1'b0, 2'b01);
        apply("R3 word usat add", 64'hFFFE_0001_8000_0000, 64'h0002_FFFE_8000_0000, 2'b01, 1'b0, 2'b01);
        apply("R3 quad usat add", 64'hFFFF_FFFF_FFFF_FFF0, 64'h20, 2'b11, 1'b0, 2'b01);
        // R4 unsigned saturating subtract
        apply("R4 byte usat sub", 64'h1020_3040_0000_FF01, 64'h2010_3050_0100_FF02, 2'b00, 1'b1, 2'b01);
        apply("R4 dword usat sub", 64'h0000_0000_8000_0000, 64'h0000_0001_7FFF_FFFF, 2'b10, 1'b1, 2'b01);
        // R5 signed saturation
        apply("R5 byte ssat", 64'h7F80_7F80_0102_FE7F, 64'h0101_8080_0102_FE01, 2'b00, 1'b0, 2'b10);
        apply("R5 word ssat sub", 64'h8000_7FFF_0005_FFFF, 64'h0001_FFFF_0007_0001, 2'b01, 1'b1, 2'b10);
        apply("R5 quad ssat", 64'h7FFF_FFFF_FFFF_FFFF, 64'd5, 2'b11, 1'b0, 2'b10);
        // R8 reserved code acts as wrap
        apply("R8 reserved byte", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'b00, 1'b0, 2'b11);
        apply("R8 reserved word sub", 64'h0000_8000_0000_0001, 64'h0001_0001_0001_0002, 2'b01, 1'b1, 2'b11);
        // R7 hold across idle cycles, R6 valid drop
        idle("R7 hold 1");
        idle("R7 hold 2");
        // R9 repeated increment climbs and sticks
        acc = 64'hF0E0_D0C0_0010_2030;
        for (int k = 0; k < 260; k++) begin
            apply("R9 climb", acc, 64'h0101_0101_0101_0101, 2'b00, 1'b0, 2'b01);
            acc = model(acc, 64'h0101_0101_0101_0101, 2'b00, 1'b0, 2'b01);
        end
        check("R9 all at max", result, 64'hFFFF_FFFF_FFFF_FFFF);
        // R6 back-to-back random vectors with idles interleaved
        for (int k = 0; k < 1200; k++) begin
            logic [63:0] ra, rb;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            if (k % 3 == 0) rb = ~ra;
            if (k % 5 == 0) rb = ra;
            apply("R6 random", ra, rb, 2'($urandom), 1'($urandom), 2'($urandom));
            if (k % 7 == 0) idle("R7 random idle");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule